// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is a state machine that keeps the chip's current power mode and moves it between eight modes: full run, slow run, slow wait, slow stop, leakage stop and three deep leakage stop levels. Software sets a run select field, a stop select field and an allow bit for the slow modes. The processor gives a sleep entry strobe and a deep-sleep flag. Wakeups come from a pending interrupt line or from a vector of wakeup lines, each with its own enable.

Which move is taken depends on the current mode. The allow bit gates entry to the slow modes. A wake-on-interrupt bit decides whether an interrupt wakeup goes back to slow run or all the way to full run. Some stop select codes are only legal from certain modes. An illegal deep-sleep request leaves the mode as it is and raises a one-cycle error flag.

Two status outputs let software wait safely before changing mode or raising clocks. One shows that slow run is active. The other shows that the supply regulator is back in full regulation. The second output comes back only after a fixed settling delay once full run is reached again.

Top module: `lpm_mode_ctrl`

## Requirements
- R1: The mode output uses these encodings: full run = 0, slow run = 1, slow wait = 2, slow stop = 3, leakage stop = 4, deep level 3 = 5, deep level 2 = 6, deep level 1 = 7. While rst_n is low, mode is 0, lp_run_stat is 0, reg_run_stat is 1 and entry_err is 0. The reset takes effect at once, from any mode.
- R2: In full run, with no sleep request, run_sel = 2'b10 moves the mode to slow run on the next clock edge, but only if allow_lp is 1. With allow_lp at 0 the mode stays in full run.
- R3: In slow run, the mode goes to full run when irq is high with wake_on_irq = 1, or when run_sel = 2'b00. The interrupt exit takes priority.
- R4: In slow run, a sleep strobe with deep_sleep = 0 enters slow wait. In slow wait, run_sel is ignored. An irq returns to slow run when wake_on_irq = 0, and to full run when wake_on_irq = 1.
- R5: Slow stop (3) is entered by a deep sleep strobe in two cases: from slow run with stop_sel 3'b000 or 3'b010, or from full run with stop_sel 3'b010 and allow_lp = 1. An irq leaves slow stop for slow run when wake_on_irq = 0, and for full run when wake_on_irq = 1.
- R6: A deep sleep strobe with stop_sel 3'b011 enters leakage stop (4) from either full run or slow run. Leakage stop exits to full run only when a wake_src bit is high and its wake_en bit is also high. Interrupts are ignored there.
- R7: Only from full run, a deep sleep strobe with stop_sel 3'b100 selects a deep stop level from deep_lvl: 2'b11 gives mode 5, 2'b10 gives mode 6, 2'b01 gives mode 7. These modes exit to full run only on an enabled wake line. Interrupts are ignored.
- R8: A deep sleep strobe whose stop_sel and deep_lvl pair, or allow_lp value, is not legal for the current run mode leaves the mode unchanged. entry_err is then high for exactly the one cycle after that edge.
- R9: lp_run_stat is 1 exactly while the mode is slow run. It changes on the same edge as the mode.
- R10: reg_run_stat drops on the edge that leaves full run and stays low in every other mode. After a return to full run it rises on the 4th clock edge following the edge that entered full run (SETTLE_CYCLES = 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_sel | input | 2 | Run mode select: 2'b10 slow, 2'b00 full |
| allow_lp | input | 1 | Permits entry to slow run or slow stop from full run |
| stop_sel | input | 3 | Stop mode select code |
| deep_lvl | input | 2 | Deep stop level for stop_sel 3'b100 |
| deep_sleep | input | 1 | Processor deep-sleep flag |
| sleep_req | input | 1 | Processor sleep entry strobe |
| irq | input | 1 | Pending interrupt |
| wake_on_irq | input | 1 | Interrupt wakeup goes to full run when 1 |
| wake_src | input | WAKE_W | Wakeup lines |
| wake_en | input | WAKE_W | Per-line wakeup enables |
| mode | output | 3 | Current mode (encoding in R1) |
| lp_run_stat | output | 1 | Slow run active |
| reg_run_stat | output | 1 | Regulator in full regulation |
| entry_err | output | 1 | One-cycle flag for an illegal sleep request |

## Verification
The bench looks for mix-ups between source modes. It tries a deep stop code from slow run, slow stop without the allow bit, and undefined level codes. A design that checks only the code would move anyway, or would miss the error pulse. It sends interrupts and disabled wake lines into the leakage stops, where a loose exit rule would drop back to full run. It also steps the regulator status one cycle at a time after a return to full run, so a timer that starts one edge early or late shows up as an off-by-one. It resets from slow run to confirm that the status bits jump straight to their run values.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      M_RUN      = 3'd0,
      M_SLOWRUN  = 3'd1,
      M_SLOWWAIT = 3'd2,
      M_SLOWSTOP = 3'd3,
      M_LEAKSTOP = 3'd4,
      M_DEEP3    = 3'd5,
      M_DEEP2    = 3'd6,
      M_DEEP1    = 3'd7
   } lp_mode_e;

   localparam logic [1:0] RS_FULL = 2'b00;
   localparam logic [1:0] RS_SLOW = 2'b10;

   localparam logic [2:0] SS_PLAIN = 3'b000;
   localparam logic [2:0] SS_SLOW  = 3'b010;
   localparam logic [2:0] SS_LEAK  = 3'b011;
   localparam logic [2:0] SS_DEEP  = 3'b100;

   function automatic logic is_deep(lp_mode_e m);
      return (m == M_DEEP3) || (m == M_DEEP2) || (m == M_DEEP1);
   endfunction

   function automatic logic is_latched(lp_mode_e m);
      return (m == M_LEAKSTOP) || is_deep(m);
   endfunction

endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
   parameter int WAKE_W = 4
) (
   input  logic [WAKE_W-1:0] src,
   input  logic [WAKE_W-1:0] en,
   output logic              hit
);

   logic [WAKE_W-1:0] qual;

   generate
      for (genvar i = 0; i < WAKE_W; i++) begin : g_line
         assign qual[i] = src[i] & en[i];
      end
   endgenerate

   assign hit = |qual;

endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
   parameter int SETTLE_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_now,
   input  logic run_next,
   output logic reg_ok
);

   localparam int CW = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         reg_ok <= 1'b1;
      end else if (!run_next) begin
         cnt_q  <= '0;
         reg_ok <= 1'b0;
      end else if (run_now && !reg_ok) begin
         if (cnt_q == LAST) begin
            reg_ok <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R10: regulator status never high outside full run
   a_r10_low_off_run: assert property (@(posedge clk) disable iff (!rst_n)
      !run_now |-> !reg_ok);

   // R10: status only rises after at least one settled cycle in full run
   a_r10_rise_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_ok) |-> (run_now && $past(run_now)));

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic [1:0] run_sel,
   input  logic      allow_lp,
   input  logic [2:0] stop_sel,
   input  logic [1:0] deep_lvl,
   input  logic      deep_sleep,
   input  logic      sleep_req,
   input  logic      irq,
   input  logic      wake_on_irq,
   input  logic      wake_hit,
   output lp_mode_e  mode_q,
   output lp_mode_e  mode_d,
   output logic      lp_run_q,
   output logic      err_q
);

   logic deep_req, light_req, err_d;

   assign deep_req  = sleep_req &&  deep_sleep;
   assign light_req = sleep_req && !deep_sleep;

   always_comb begin
      mode_d = mode_q;
      err_d  = 1'b0;
      case (mode_q)
         M_RUN: begin
            if (deep_req) begin
               case (stop_sel)
                  SS_SLOW: begin
                     if (allow_lp) mode_d = M_SLOWSTOP;
                     else          err_d  = 1'b1;
                  end
                  SS_LEAK: mode_d = M_LEAKSTOP;
                  SS_DEEP: begin
                     case (deep_lvl)
                        2'b11:   mode_d = M_DEEP3;
                        2'b10:   mode_d = M_DEEP2;
                        2'b01:   mode_d = M_DEEP1;
                        default: err_d  = 1'b1;
                     endcase
                  end
                  default: err_d = 1'b1;
               endcase
            end else if (!light_req && run_sel == RS_SLOW && allow_lp) begin
               mode_d = M_SLOWRUN;
            end
         end
         M_SLOWRUN: begin
            if (irq && wake_on_irq) begin
               mode_d = M_RUN;
            end else if (run_sel == RS_FULL) begin
               mode_d = M_RUN;
            end else if (light_req) begin
               mode_d = M_SLOWWAIT;
            end else if (deep_req) begin
               case (stop_sel)
                  SS_PLAIN, SS_SLOW: mode_d = M_SLOWSTOP;
                  SS_LEAK:           mode_d = M_LEAKSTOP;
                  default:           err_d  = 1'b1;
               endcase
            end
         end
         M_SLOWWAIT, M_SLOWSTOP: begin
            if (irq) mode_d = wake_on_irq ? M_RUN : M_SLOWRUN;
         end
         default: begin
            if (wake_hit) mode_d = M_RUN;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= M_RUN;
         lp_run_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         mode_q   <= mode_d;
         lp_run_q <= (mode_d == M_SLOWRUN);
         err_q    <= err_d;
      end
   end

   // R2: without the allow bit full run never reaches a slow mode
   a_r2_allow_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_RUN && !allow_lp) |=> (mode_q != M_SLOWRUN && mode_q != M_SLOWSTOP));

   // R6: leakage stops hold until an enabled wake line fires
   a_r6_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (is_latched(mode_q) && !wake_hit) |=> $stable(mode_q));

   // R7: deep stop levels are reached only from full run
   a_r7_deep_src: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != M_RUN && !is_deep(mode_q)) |=> !is_deep(mode_q));

   // R8: an error pulse comes with an unchanged mode
   a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (mode_q == $past(mode_q)));

   // R9: slow run flag agrees with the mode register
   a_r9_lp_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_SLOWRUN) |-> lp_run_q);

endmodule

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl
   import lpm_pkg::*;
#(
   parameter int WAKE_W        = 4,
   parameter int SETTLE_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        run_sel,
   input  logic              allow_lp,
   input  logic [2:0]        stop_sel,
   input  logic [1:0]        deep_lvl,
   input  logic              deep_sleep,
   input  logic              sleep_req,
   input  logic              irq,
   input  logic              wake_on_irq,
   input  logic [WAKE_W-1:0] wake_src,
   input  logic [WAKE_W-1:0] wake_en,
   output logic [2:0]        mode,
   output logic              lp_run_stat,
   output logic              reg_run_stat,
   output logic              entry_err
);

   generate
      if (WAKE_W < 1 || WAKE_W > 32) begin : g_bad_wake_w
         $error("lpm_mode_ctrl: WAKE_W must be 1..32");
      end
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("lpm_mode_ctrl: SETTLE_CYCLES must be at least 1");
      end
   endgenerate

   logic     wake_hit;
   lp_mode_e mode_q, mode_d;

   lpm_wake_detect #(.WAKE_W(WAKE_W)) u_wake (
      .src (wake_src),
      .en  (wake_en),
      .hit (wake_hit)
   );

   lpm_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_sel     (run_sel),
      .allow_lp    (allow_lp),
      .stop_sel    (stop_sel),
      .deep_lvl    (deep_lvl),
      .deep_sleep  (deep_sleep),
      .sleep_req   (sleep_req),
      .irq         (irq),
      .wake_on_irq (wake_on_irq),
      .wake_hit    (wake_hit),
      .mode_q      (mode_q),
      .mode_d      (mode_d),
      .lp_run_q    (lp_run_stat),
      .err_q       (entry_err)
   );

   lpm_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_now  (mode_q == M_RUN),
      .run_next (mode_d == M_RUN),
      .reg_ok   (reg_run_stat)
   );

   assign mode = mode_q;

endmodule

// File: tb/tb_lpm_mode_ctrl.sv
module tb_lpm_mode_ctrl;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] run_sel;
   logic       allow_lp;
   logic [2:0] stop_sel;
   logic [1:0] deep_lvl;
   logic       deep_sleep;
   logic       sleep_req;
   logic       irq;
   logic       wake_on_irq;
   logic [3:0] wake_src;
   logic [3:0] wake_en;
   logic [2:0] mode;
   logic       lp_run_stat;
   logic       reg_run_stat;
   logic       entry_err;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   lpm_mode_ctrl #(.WAKE_W(4), .SETTLE_CYCLES(4)) dut (
      .clk(clk), .rst_n(rst_n), .run_sel(run_sel), .allow_lp(allow_lp),
      .stop_sel(stop_sel), .deep_lvl(deep_lvl), .deep_sleep(deep_sleep),
      .sleep_req(sleep_req), .irq(irq), .wake_on_irq(wake_on_irq),
      .wake_src(wake_src), .wake_en(wake_en), .mode(mode),
      .lp_run_stat(lp_run_stat), .reg_run_stat(reg_run_stat), .entry_err(entry_err)
   );

   // {req[23:20], run_sel[19:18], allow[17], stop_sel[16:14], lvl[13:12],
   //  deep[11], sleep[10], irq[9], woi[8], wake[7:4], exp_mode[3:1], exp_err[0]}
   localparam int NV = 32;
   localparam logic [23:0] VEC [NV] = '{
      {4'd2, 2'b10,1'b0,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b0000,3'd0,1'b0}, // R2 blocked
      {4'd2, 2'b10,1'b1,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b0000,3'd1,1'b0}, // R2 enter slow run
      {4'd4, 2'b10,1'b1,3'b000,2'b00,1'b0,1'b1,1'b0,1'b0,4'b0000,3'd2,1'b0}, // R4 wait
      {4'd4, 2'b10,1'b1,3'b000,2'b00,1'b0,1'b0,1'b1,1'b0,4'b0000,3'd1,1'b0}, // R4 back to slow run
      {4'd5, 2'b10,1'b1,3'b000,2'b00,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd3,1'b0}, // R5 stop via 000
      {4'd5, 2'b10,1'b1,3'b000,2'b00,1'b0,1'b0,1'b1,1'b1,4'b0000,3'd0,1'b0}, // R5 irq to full
      {4'd5, 2'b00,1'b1,3'b010,2'b00,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd3,1'b0}, // R5 from full run
      {4'd5, 2'b00,1'b1,3'b000,2'b00,1'b0,1'b0,1'b1,1'b0,4'b0000,3'd1,1'b0}, // R5 irq to slow
      {4'd3, 2'b00,1'b1,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b0000,3'd0,1'b0}, // R3 run_sel exit
      {4'd8, 2'b00,1'b0,3'b010,2'b00,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd0,1'b1}, // R8 no allow
      {4'd6, 2'b00,1'b0,3'b011,2'b00,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd4,1'b0}, // R6 enter
      {4'd6, 2'b00,1'b0,3'b000,2'b00,1'b0,1'b0,1'b1,1'b1,4'b0000,3'd4,1'b0}, // R6 irq ignored
      {4'd6, 2'b00,1'b0,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b1010,3'd4,1'b0}, // R6 disabled lines
      {4'd6, 2'b00,1'b0,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b0100,3'd0,1'b0}, // R6 wake
      {4'd2, 2'b10,1'b1,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b0000,3'd1,1'b0}, // R2
      {4'd7, 2'b10,1'b1,3'b100,2'b11,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd1,1'b1}, // R7 illegal from slow
      {4'd6, 2'b10,1'b1,3'b011,2'b00,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd4,1'b0}, // R6 from slow run
      {4'd6, 2'b00,1'b0,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b0001,3'd0,1'b0}, // R6 wake
      {4'd7, 2'b00,1'b0,3'b100,2'b11,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd5,1'b0}, // R7 level 3
      {4'd7, 2'b00,1'b0,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b0001,3'd0,1'b0}, // R7 wake
      {4'd7, 2'b00,1'b0,3'b100,2'b10,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd6,1'b0}, // R7 level 2
      {4'd7, 2'b00,1'b0,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b0100,3'd0,1'b0}, // R7 wake
      {4'd7, 2'b00,1'b0,3'b100,2'b01,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd7,1'b0}, // R7 level 1
      {4'd7, 2'b00,1'b0,3'b000,2'b00,1'b0,1'b0,1'b1,1'b1,4'b0000,3'd7,1'b0}, // R7 irq ignored
      {4'd7, 2'b00,1'b0,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b0001,3'd0,1'b0}, // R7 wake
      {4'd8, 2'b00,1'b0,3'b100,2'b00,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd0,1'b1}, // R8 bad level
      {4'd8, 2'b00,1'b0,3'b111,2'b00,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd0,1'b1}, // R8 bad code
      {4'd2, 2'b10,1'b1,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b0000,3'd1,1'b0}, // R2
      {4'd8, 2'b10,1'b1,3'b001,2'b00,1'b1,1'b1,1'b0,1'b0,4'b0000,3'd1,1'b1}, // R8 bad from slow
      {4'd4, 2'b10,1'b1,3'b000,2'b00,1'b0,1'b1,1'b0,1'b0,4'b0000,3'd2,1'b0}, // R4 wait
      {4'd4, 2'b00,1'b1,3'b000,2'b00,1'b0,1'b0,1'b0,1'b0,4'b0000,3'd2,1'b0}, // R4 run_sel ignored
      {4'd4, 2'b00,1'b1,3'b000,2'b00,1'b0,1'b0,1'b1,1'b1,4'b0000,3'd0,1'b0}  // R4 irq to full
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      run_sel = 2'b00; allow_lp = 1'b0; stop_sel = 3'b000; deep_lvl = 2'b00;
      deep_sleep = 1'b0; sleep_req = 1'b0; irq = 1'b0; wake_on_irq = 1'b0;
      wake_src = 4'b0000;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n   = 1'b0;
      wake_en = 4'b0101;
      idle();
      repeat (3) @(negedge clk);
      // R1 reset values
      chk("R1 mode", int'(mode), 0);
      chk("R1 lp_run_stat", int'(lp_run_stat), 0);
      chk("R1 reg_run_stat", int'(reg_run_stat), 1);
      chk("R1 entry_err", int'(entry_err), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [23:0] v;
         v = VEC[i];
         run_sel = v[19:18]; allow_lp = v[17]; stop_sel = v[16:14];
         deep_lvl = v[13:12]; deep_sleep = v[11]; sleep_req = v[10];
         irq = v[9]; wake_on_irq = v[8]; wake_src = v[7:4];
         @(negedge clk);
         chk($sformatf("R%0d vec %0d mode", v[23:20], i), int'(mode), int'(v[3:1]));
         chk($sformatf("R8 vec %0d entry_err", i), int'(entry_err), int'(v[0]));
         chk($sformatf("R9 vec %0d lp_run_stat", i), int'(lp_run_stat),
             int'(v[3:1] == 3'd1));
      end

      idle();
      repeat (6) @(negedge clk);
      chk("R10 settled in full run", int'(reg_run_stat), 1);

      run_sel = 2'b10; allow_lp = 1'b1;
      @(negedge clk);
      chk("R2 mode", int'(mode), 1);
      chk("R10 low in slow run", int'(reg_run_stat), 0);
      chk("R9 slow run flag", int'(lp_run_stat), 1);

      run_sel = 2'b00;
      for (int k = 0; k <= 4; k++) begin
         @(negedge clk);
         chk($sformatf("R10 settle step %0d", k), int'(reg_run_stat), (k == 4) ? 1 : 0);
      end
      chk("R3 back to full run", int'(mode), 0);

      // Reset from slow run
      run_sel = 2'b10; allow_lp = 1'b1;
      @(negedge clk);
      chk("R2 re-enter", int'(mode), 1);
      rst_n = 1'b0;
      run_sel = 2'b00;
      #1;
      chk("R1 reset mode", int'(mode), 0);
      chk("R1 reset reg_run_stat", int'(reg_run_stat), 1);
      chk("R1 reset lp_run_stat", int'(lp_run_stat), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", int'(mode), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule